// File: doc/BRIEF.md
# Sleep-Retained Fine Counter with Wakeup Handshake

This block owns the 10-bit fine counter of a radio timing core and keeps its value across a low-power sleep. A small two-state sequencer tracks whether the core is awake or asleep. On the way into sleep it copies the live count into an always-on retention register. On the way out it loads that register back into the counter, so that the count picks up where it left off, or at a value that software has placed there.

Software reaches the block through a minimal register port with two locations. Location 0 holds the retained count, and software can change it only while the core sleeps. Location 1 holds a wakeup request bit and a read-only copy of the wakeup interrupt. The request is gated by the sleep state. It crosses into a slow low-power clock through a synchronizer and a short pipeline. The resulting interrupt rises a fixed number of slow cycles after the request.

Top module: `slk_fcnt_keeper`

## Requirements
- R1: After reset, `fcnt` is 0, `asleep` is 0, `lp_wake_irq` is 0, and both locations read back as 0.
- R2: While awake, each cycle with `fcnt_tick` high advances `fcnt` by one, and the value 1023 is followed by 0. Without a tick, `fcnt` holds.
- R3: When `sleep_req` is high while awake, `sleep_entry` is high for that one cycle. From the next cycle on, `asleep` is 1 and location 0 holds the count of the entry cycle. The counter does not advance in the entry cycle and stays frozen while asleep.
- R4: When `core_wake` is high while asleep, `wake_exit` is high for that one cycle. In the next cycle, `asleep` is 0 and `fcnt` equals the retained value. The load wins over a tick in the same cycle.
- R5: Location 0 is selected when `bus_sel` is 0. A write to it while asleep stores `bus_wdata[9:0]`. A read returns the retained value in bits 9:0 and zero in bits 15:10.
- R6: A write to location 0 while awake, in the entry cycle or in the exit cycle leaves the retained value unchanged.
- R7: Location 1 is selected when `bus_sel` is 1. Bit 0 is the wakeup request, which can be written and read back. Bit 1 is the interrupt status and cannot be written. All other bits read 0.
- R8: While asleep, setting the request raises `lp_wake_irq` between 3 and 4 slow periods later, plus at most one fast cycle. While the core is awake, the request does not raise `lp_wake_irq`.
- R9: Bit 1 of location 1 follows `lp_wake_irq` after a two-flop synchronizer in the fast clock.
- R10: `sleep_req` while asleep and `core_wake` while awake give no pulse and change neither the state nor `fcnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock of the core and the register port |
| lp_clk | input | 1 | Slow low-power clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fcnt_tick | input | 1 | Advance enable for the fine counter |
| sleep_req | input | 1 | Core asks to enter sleep |
| core_wake | input | 1 | Core power-up done, leave sleep |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 retained count, 1 control/status |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data of the selected location |
| fcnt | output | 10 | Live fine counter value |
| asleep | output | 1 | Core is in the sleep state |
| sleep_entry | output | 1 | One-cycle pulse on sleep entry |
| wake_exit | output | 1 | One-cycle pulse on wakeup |
| lp_wake_irq | output | 1 | Wakeup interrupt in the slow clock domain |

## Verification
A wrong retained value stays invisible until the next wakeup. It then shows up in `fcnt` in the cycle after `wake_exit`, and it can also be read at location 0 as soon as the core is asleep. A sleep state that has drifted freezes or unfreezes the counter, and it shows at `asleep` and in the pulses within one cycle. A fault in the slow pipeline moves the rising edge of `lp_wake_irq` outside its three-to-four period window. Such a fault reaches the status bit two fast cycles after that.

// File: rtl/slk_pkg.sv
package slk_pkg;

    typedef enum logic {
        ST_AWAKE  = 1'b0,
        ST_ASLEEP = 1'b1
    } slk_state_e;

    localparam logic SEL_RET  = 1'b0;
    localparam logic SEL_CTRL = 1'b1;

    localparam int unsigned CTRL_REQ_BIT = 0;
    localparam int unsigned CTRL_STS_BIT = 1;

endpackage

// File: rtl/slk_fsm.sv
module slk_fsm
    import slk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic core_wake,
    output logic asleep,
    output logic entry_pulse,
    output logic exit_pulse
);

    typedef struct packed {
        slk_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d       = fsm_q;
        entry_pulse = 1'b0;
        exit_pulse  = 1'b0;
        case (fsm_q.st)
            ST_AWAKE: begin
                if (sleep_req) begin
                    entry_pulse = 1'b1;
                    fsm_d.st    = ST_ASLEEP;
                end
            end
            default: begin
                if (core_wake) begin
                    exit_pulse = 1'b1;
                    fsm_d.st   = ST_AWAKE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: ST_AWAKE};
        else        fsm_q <= fsm_d;
    end

    assign asleep = (fsm_q.st == ST_ASLEEP);

    p_entry_then_asleep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        entry_pulse |=> asleep);

    p_exit_then_awake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exit_pulse |=> !asleep);

    p_entry_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        entry_pulse |=> !entry_pulse);

endmodule

// File: rtl/slk_fine_cnt.sv
module slk_fine_cnt #(
    parameter int unsigned      CNT_W   = 10,
    parameter logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             asleep,
    input  logic             entry,
    input  logic             exit_ld,
    input  logic             ret_wr,
    input  logic [CNT_W-1:0] ret_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] ret
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ret;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // restore has priority over counting
        if (exit_ld) begin
            st_d.cnt = st_q.ret;
        end else if (!asleep && !entry && tick) begin
            st_d.cnt = (st_q.cnt == CNT_TOP) ? '0 : st_q.cnt + 1'b1;
        end
        // capture on entry; software writes only in steady sleep
        if (entry) begin
            st_d.ret = st_q.cnt;
        end else if (asleep && !exit_ld && ret_wr) begin
            st_d.ret = ret_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign ret = st_q.ret;

    p_frozen_asleep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && !exit_ld) |=> cnt == $past(cnt));

    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        entry |=> ret == $past(cnt));

    p_restore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exit_ld |=> cnt == $past(ret));

    p_awake_ret_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!asleep && !entry) |=> ret == $past(ret));

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!asleep && !entry && tick && cnt == CNT_TOP) |=> cnt == '0);

endmodule

// File: rtl/slk_wake_sync.sv
module slk_wake_sync #(
    parameter int unsigned SYNC_N = 2,
    parameter int unsigned PIPE_N = 2,
    parameter int unsigned STS_N  = 2
) (
    input  logic clk,
    input  logic lp_clk,
    input  logic rst_n,
    input  logic asleep,
    input  logic req_wr,
    input  logic req_wdata,
    output logic req,
    output logic lp_irq,
    output logic irq_sts
);

    localparam int unsigned LP_N = SYNC_N + PIPE_N;

    typedef struct packed {
        logic             req;
        logic             lp_src;
        logic [STS_N-1:0] sts;
    } fast_t;

    typedef struct packed {
        logic [LP_N-1:0] sh;
    } slow_t;

    fast_t fst_d, fst_q;
    slow_t slw_d, slw_q;

    always_comb begin
        fst_d = fst_q;
        if (req_wr) fst_d.req = req_wdata;
        // registered source for the crossing, gated by sleep
        fst_d.lp_src = fst_d.req & asleep;
        fst_d.sts    = {fst_q.sts[STS_N-2:0], slw_q.sh[LP_N-1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fst_q <= '0;
        else        fst_q <= fst_d;
    end

    always_comb begin
        slw_d.sh = {slw_q.sh[LP_N-2:0], fst_q.lp_src};
    end

    always_ff @(posedge lp_clk or negedge rst_n) begin
        if (!rst_n) slw_q <= '0;
        else        slw_q <= slw_d;
    end

    assign req     = fst_q.req;
    assign lp_irq  = slw_q.sh[LP_N-1];
    assign irq_sts = fst_q.sts[STS_N-1];

    p_gate_awake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !asleep |=> !fst_q.lp_src);

endmodule

// File: rtl/slk_fcnt_keeper.sv
module slk_fcnt_keeper
    import slk_pkg::*;
#(
    parameter int unsigned      CNT_W   = 10,
    parameter int unsigned      BUS_W   = 16,
    parameter logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}},
    parameter int unsigned      SYNC_N  = 2,
    parameter int unsigned      PIPE_N  = 2,
    parameter int unsigned      STS_N   = 2
) (
    input  logic             clk,
    input  logic             lp_clk,
    input  logic             rst_n,
    input  logic             fcnt_tick,
    input  logic             sleep_req,
    input  logic             core_wake,
    input  logic             bus_wr,
    input  logic             bus_sel,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic [CNT_W-1:0] fcnt,
    output logic             asleep,
    output logic             sleep_entry,
    output logic             wake_exit,
    output logic             lp_wake_irq
);

    logic [CNT_W-1:0] ret_val;
    logic             req_bit;
    logic             irq_sts;
    logic             ret_wr;
    logic             ctrl_wr;
    logic             unused_wdata_hi;

    assign ret_wr          = bus_wr && (bus_sel == SEL_RET);
    assign ctrl_wr         = bus_wr && (bus_sel == SEL_CTRL);
    assign unused_wdata_hi = ^bus_wdata[BUS_W-1:CNT_W];

    slk_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .core_wake   (core_wake),
        .asleep      (asleep),
        .entry_pulse (sleep_entry),
        .exit_pulse  (wake_exit)
    );

    slk_fine_cnt #(
        .CNT_W   (CNT_W),
        .CNT_TOP (CNT_TOP)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (fcnt_tick),
        .asleep    (asleep),
        .entry     (sleep_entry),
        .exit_ld   (wake_exit),
        .ret_wr    (ret_wr),
        .ret_wdata (bus_wdata[CNT_W-1:0]),
        .cnt       (fcnt),
        .ret       (ret_val)
    );

    slk_wake_sync #(
        .SYNC_N (SYNC_N),
        .PIPE_N (PIPE_N),
        .STS_N  (STS_N)
    ) u_wake (
        .clk       (clk),
        .lp_clk    (lp_clk),
        .rst_n     (rst_n),
        .asleep    (asleep),
        .req_wr    (ctrl_wr),
        .req_wdata (bus_wdata[CTRL_REQ_BIT]),
        .req       (req_bit),
        .lp_irq    (lp_wake_irq),
        .irq_sts   (irq_sts)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel == SEL_RET) begin
            bus_rdata[CNT_W-1:0] = ret_val;
        end else begin
            bus_rdata[CTRL_REQ_BIT] = req_bit;
            bus_rdata[CTRL_STS_BIT] = irq_sts;
        end
    end

endmodule

// File: tb/sim_slk_fcnt_keeper.sv
`timescale 1ns/1ps
module sim_slk_fcnt_keeper;

    localparam int CNT_TOP = 1023;
    localparam real LP_PER = 56.0;

    localparam logic [3:0] OP_TICK = 4'd0;
    localparam logic [3:0] OP_SLP  = 4'd1;
    localparam logic [3:0] OP_WAKE = 4'd2;
    localparam logic [3:0] OP_WRET = 4'd3;
    localparam logic [3:0] OP_CRET = 4'd4;
    localparam logic [3:0] OP_CCNT = 4'd5;
    localparam logic [3:0] OP_CSLP = 4'd6;

    localparam int NV = 24;
    // {requirement, op, argument or expected value}
    localparam logic [23:0] VEC [0:NV-1] = '{
        {4'd2,  OP_TICK, 16'd5},      // R2
        {4'd2,  OP_CCNT, 16'd5},      // R2
        {4'd3,  OP_SLP,  16'd0},      // R3
        {4'd3,  OP_CSLP, 16'd1},      // R3
        {4'd3,  OP_CRET, 16'd5},      // R3
        {4'd3,  OP_TICK, 16'd3},      // R3 frozen
        {4'd3,  OP_CCNT, 16'd5},      // R3
        {4'd5,  OP_WRET, 16'd300},    // R5
        {4'd5,  OP_CRET, 16'd300},    // R5
        {4'd4,  OP_WAKE, 16'd0},      // R4
        {4'd4,  OP_CSLP, 16'd0},      // R4
        {4'd4,  OP_CCNT, 16'd300},    // R4
        {4'd2,  OP_TICK, 16'd2},      // R2
        {4'd2,  OP_CCNT, 16'd302},    // R2
        {4'd6,  OP_WRET, 16'd77},     // R6 awake write
        {4'd6,  OP_CRET, 16'd300},    // R6
        {4'd6,  OP_CCNT, 16'd302},    // R6
        {4'd3,  OP_SLP,  16'd0},      // R3
        {4'd3,  OP_CRET, 16'd302},    // R3
        {4'd5,  OP_WRET, 16'hFC12},   // R5 upper bits dropped
        {4'd5,  OP_CRET, 16'h0012},   // R5
        {4'd4,  OP_WAKE, 16'd0},      // R4
        {4'd4,  OP_CCNT, 16'h0012},   // R4
        {4'd4,  OP_CSLP, 16'd0}       // R4
    };

    logic        clk, lp_clk, rst_n;
    logic        fcnt_tick, sleep_req, core_wake, bus_wr, bus_sel;
    logic [15:0] bus_wdata, bus_rdata;
    logic [9:0]  fcnt;
    logic        asleep, sleep_entry, wake_exit, lp_wake_irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    slk_fcnt_keeper u0 (
        .clk         (clk),
        .lp_clk      (lp_clk),
        .rst_n       (rst_n),
        .fcnt_tick   (fcnt_tick),
        .sleep_req   (sleep_req),
        .core_wake   (core_wake),
        .bus_wr      (bus_wr),
        .bus_sel     (bus_sel),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .fcnt        (fcnt),
        .asleep      (asleep),
        .sleep_entry (sleep_entry),
        .wake_exit   (wake_exit),
        .lp_wake_irq (lp_wake_irq)
    );

    initial begin
        clk = 1'b0;
        forever #4 clk = ~clk;
    end

    initial begin
        lp_clk = 1'b0;
        #3;
        forever #28 lp_clk = ~lp_clk;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        fcnt_tick = 0; sleep_req = 0; core_wake = 0;
        bus_wr = 0; bus_sel = 0; bus_wdata = '0;
    endtask

    task automatic cyc(input logic t, input logic s, input logic w,
                       input logic wr, input logic sel, input logic [15:0] wd);
        fcnt_tick = t; sleep_req = s; core_wake = w;
        bus_wr = wr; bus_sel = sel; bus_wdata = wd;
        @(negedge clk);
        idle();
    endtask

    task automatic rd(input logic sel, output logic [15:0] val);
        bus_sel = sel;
        #1;
        val = bus_rdata;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        realtime t_req, t_irq;
        int g;
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 fcnt", fcnt, 0);
        chk("R1 asleep", asleep, 0);
        chk("R1 irq", lp_wake_irq, 0);
        rd(0, v); chk("R1 ret", v, 0);
        rd(1, v); chk("R1 ctrl", v, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [3:0]  rq;
            logic [3:0]  op;
            logic [15:0] arg;
            string tag;
            {rq, op, arg} = VEC[i];
            tag = $sformatf("R%0d vec%0d", rq, i);
            case (op)
                OP_TICK: for (int k = 0; k < arg; k++) cyc(1, 0, 0, 0, 0, 0);
                OP_SLP:  cyc(0, 1, 0, 0, 0, 0);
                OP_WAKE: cyc(0, 0, 1, 0, 0, 0);
                OP_WRET: cyc(0, 0, 0, 1, 0, arg);
                OP_CRET: begin rd(0, v); chk(tag, v, arg); end
                OP_CCNT: chk(tag, fcnt, arg);
                default: chk(tag, asleep, arg);
            endcase
        end

        // R2 wrap
        cyc(0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, CNT_TOP - 1);
        cyc(0, 0, 1, 0, 0, 0);
        chk("R2 preload", fcnt, CNT_TOP - 1);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R2 top", fcnt, CNT_TOP);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R2 wrap", fcnt, 0);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R2 hold", fcnt, 0);

        // R3 entry pulse and R6 write in entry cycle
        cyc(1, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        sleep_req = 1; fcnt_tick = 1; bus_wr = 1; bus_sel = 0; bus_wdata = 16'd99;
        #1;
        chk("R3 entry pulse", sleep_entry, 1);
        @(negedge clk); idle();
        chk("R3 pulse one cycle", sleep_entry, 0);
        chk("R3 no advance", fcnt, 2);
        rd(0, v); chk("R6 entry-cycle write", v, 2);

        // R10 sleep_req while asleep
        sleep_req = 1;
        #1;
        chk("R10 no entry asleep", sleep_entry, 0);
        @(negedge clk); idle();
        chk("R10 still asleep", asleep, 1);

        // R4 load priority over tick, R6 write in exit cycle
        cyc(0, 0, 0, 1, 0, 16'd500);
        core_wake = 1; fcnt_tick = 1; bus_wr = 1; bus_sel = 0; bus_wdata = 16'd7;
        #1;
        chk("R4 exit pulse", wake_exit, 1);
        @(negedge clk); idle();
        chk("R4 load wins", fcnt, 500);
        chk("R4 exit one cycle", wake_exit, 0);
        rd(0, v); chk("R6 exit-cycle write", v, 500);

        // R10 core_wake while awake
        core_wake = 1;
        #1;
        chk("R10 no exit awake", wake_exit, 0);
        @(negedge clk); idle();
        chk("R10 fcnt kept", fcnt, 500);
        chk("R10 awake", asleep, 0);

        // R7 control register
        cyc(0, 0, 0, 1, 1, 16'hFFFF);
        rd(1, v); chk("R7 ctrl ro bits", v, 1);
        // R8 awake gating
        repeat (50) @(negedge clk);
        chk("R8 gated awake", lp_wake_irq, 0);
        rd(1, v); chk("R9 status low awake", v, 1);
        cyc(0, 0, 0, 1, 1, 16'h0000);
        rd(1, v); chk("R7 ctrl cleared", v, 0);

        // R8 latency while asleep
        cyc(0, 1, 0, 0, 0, 0);
        repeat (10) @(negedge clk);
        cyc(0, 0, 0, 1, 1, 16'h0001);
        t_req = $realtime - 4.0;
        g = 0;
        while (!lp_wake_irq && g < 2000) begin #1; g++; end
        t_irq = $realtime;
        chk("R8 irq rose", lp_wake_irq, 1);
        chk("R8 min delay", (t_irq - t_req) >= 3.0 * LP_PER, 1);
        chk("R8 max delay", (t_irq - t_req) <= 4.0 * LP_PER + 9.0, 1);
        @(negedge clk);
        repeat (3) @(negedge clk);
        rd(1, v); chk("R9 status high", v, 3);

        // wake the core; request gated off again
        cyc(0, 0, 1, 0, 0, 0);
        repeat (40) @(negedge clk);
        chk("R8 irq falls awake", lp_wake_irq, 0);
        rd(1, v); chk("R9 status follows", v, 1);
        cyc(0, 0, 0, 1, 1, 16'h0000);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule